// File: doc/BRIEF.md
# SPI Command Frame Parser

This block sits behind an SPI peripheral deserializer. It takes whole 16-bit words together with a one-cycle pulse that marks the start of a frame, which comes when chip select asserts. The first word after that pulse is the command word. The block decodes it into a command code, a register start address, the number of write-data words that follow, the number of read-data slots the peripheral must return, and the count of extra END bytes.

Every later word of the frame gets a tag. A word can be a write-data word, the controller CRC word, a read-data slot, a surplus word after the frame is complete, or a dropped word after an illegal command. Each tag carries its position inside its phase. The tag stream and the held command fields go to a CRC checker and to the register and forwarding logic.

A frame-start pulse always restarts parsing. An aborted frame therefore never affects the frame that follows it.

Top module: `spi_cmd_parser`

## Requirements
- R1: After reset, tag_valid is 0, tag_kind is 0, cmd_bad is 0 and cmd_code is 0. Whenever tag_valid is 0, tag_kind is 0.
- R2: The first valid word after a frame_start pulse is tagged kind 1 (command). If frame_start and word_valid are high in the same cycle, that word is the command. cmd_code takes bits 15:12 of the command word. Tags and command fields appear one clock after the word is presented.
- R3: A plain length field of value N yields N+1 write-data words, tagged kind 2 with indices 0..N, followed by one CRC word tagged kind 3. The length field sits in bits 8:0 for code 0x2, bits 11:0 for code 0x3, bits 11:7 for codes 0x6 and 0x7, and bits 3:0 for codes 0xA and 0xB.
- R4: For codes 0x4 and 0x5, the length in bits 11:7 gives exactly N write-data words. When N is 0, the word after the command is the CRC word. For codes 0x4 to 0x7, cmd_end_bytes reports bits 6:0, which allows up to 127.
- R5: Read codes 0x8 and 0x9 (length in bits 7:0) and 0xC and 0xD (length in bits 3:0) are followed by the CRC word and then N+1 read slots, tagged kind 4 with indices 0..N. cmd_rd_words reports N+1.
- R6: For register codes 0xA to 0xD, cmd_addr takes bits 7:4, and an address field of 0 reads as register 0. A nonzero bit in 11:8 sets cmd_bad.
- R7: A nonzero reserved bit sets cmd_bad. The reserved bits are 11:9 for code 0x2 and 11:8 for codes 0x8 and 0x9.
- R8: Code 0xE is legal only when bits 11:0 equal 0x1E1. A legal 0xE command has no data words and no read slots, so the next word is the CRC word. Any other value in bits 11:0 sets cmd_bad.
- R9: Codes 0x0, 0x1 and 0xF set cmd_bad. After any command with cmd_bad set, each remaining word of the frame is tagged kind 6 (dropped) until the next frame_start.
- R10: Words that arrive after the last slot of a complete frame are tagged kind 5 (surplus).
- R11: A frame_start in the middle of a frame abandons that frame. The next valid word is parsed as a command.
- R12: Valid words that arrive after reset and before the first frame_start are tagged kind 6.
- R13: A cycle with word_valid low produces no tag and does not advance the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse at chip-select assertion |
| word_valid | input | 1 | word_data holds a received word |
| word_data | input | 16 | Received word |
| tag_valid | output | 1 | A tag is presented this cycle |
| tag_kind | output | 3 | 0 none, 1 command, 2 write data, 3 CRC, 4 read slot, 5 surplus, 6 dropped |
| tag_idx | output | 13 | Position of the word inside its data or slot phase |
| tag_word | output | 16 | The word that was tagged |
| cmd_code | output | 4 | Code of the last command word |
| cmd_addr | output | 4 | Register start address |
| cmd_wr_words | output | 13 | Number of write-data words |
| cmd_rd_words | output | 13 | Number of read slots |
| cmd_end_bytes | output | 7 | Extra END-byte count |
| cmd_bad | output | 1 | The last command was illegal or malformed |

## Verification
Some properties are checked on every cycle. These are:
- an idle tag cycle always reports kind 0;
- a command tag always matches the latched code;
- write-data and read-slot indices stay below the decoded counts;
- an illegal command leads only to dropped words or to a fresh command;
- a lone frame-start pulse returns the tracker to the command phase.

The per-code field layouts and length offsets can only be shown by the bench's scenarios. The same holds for the exact order of tags through each frame, restart in the middle of a frame, and the surplus and pre-frame tags. Those scenarios check concrete words against values worked out by hand.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int CNT_W = 13;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_CMD   = 3'd1,
      K_WDATA = 3'd2,
      K_CRC   = 3'd3,
      K_RSLOT = 3'd4,
      K_EXTRA = 3'd5,
      K_DROP  = 3'd6
   } word_kind_e;

   typedef enum logic [2:0] {
      PH_CMD, PH_WDATA, PH_CRC, PH_RSLOT, PH_DONE, PH_DROP
   } phase_e;

   typedef struct packed {
      logic [3:0]       code;
      logic [3:0]       addr;
      logic [CNT_W-1:0] wr_words;
      logic [CNT_W-1:0] rd_words;
      logic [6:0]       end_bytes;
      logic             bad;
   } cmd_info_t;
endpackage

// File: rtl/spi_cmd_field_dec.sv
module spi_cmd_field_dec
   import spi_cmd_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] word,
   output cmd_info_t         info
);
   localparam logic [11:0] RESET_KEY = 12'h1E1;

   always_comb begin
      info      = '0;
      info.code = word[15:12];
      unique case (word[15:12])
         4'h2: begin
            info.wr_words = {4'd0, word[8:0]} + 13'd1;
            info.bad      = |word[11:9];
         end
         4'h3: info.wr_words = {1'b0, word[11:0]} + 13'd1;
         4'h4, 4'h5: begin
            info.wr_words  = {8'd0, word[11:7]};
            info.end_bytes = word[6:0];
         end
         4'h6, 4'h7: begin
            info.wr_words  = {8'd0, word[11:7]} + 13'd1;
            info.end_bytes = word[6:0];
         end
         4'h8, 4'h9: begin
            info.rd_words = {5'd0, word[7:0]} + 13'd1;
            info.bad      = |word[11:8];
         end
         4'hA, 4'hB: begin
            info.addr     = word[7:4];
            info.wr_words = {9'd0, word[3:0]} + 13'd1;
            info.bad      = |word[11:8];
         end
         4'hC, 4'hD: begin
            info.addr     = word[7:4];
            info.rd_words = {9'd0, word[3:0]} + 13'd1;
            info.bad      = |word[11:8];
         end
         4'hE: info.bad = (word[11:0] != RESET_KEY);
         default: info.bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/spi_frame_tracker.sv
module spi_frame_tracker
   import spi_cmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             word_valid,
   input  logic             dec_bad,
   input  logic [CNT_W-1:0] dec_wr,
   input  logic [CNT_W-1:0] dec_rd,
   output word_kind_e       kind,
   output logic [CNT_W-1:0] idx
);
   phase_e           phase, eff, nxt_phase;
   logic [CNT_W-1:0] cnt, nxt_cnt, wr_tgt, rd_tgt, nxt_wr, nxt_rd;

   always_comb begin
      eff       = frame_start ? PH_CMD : phase;
      kind      = K_NONE;
      idx       = '0;
      nxt_phase = frame_start ? PH_CMD : phase;
      nxt_cnt   = frame_start ? '0 : cnt;
      nxt_wr    = wr_tgt;
      nxt_rd    = rd_tgt;
      if (word_valid) begin
         unique case (eff)
            PH_CMD: begin
               kind      = K_CMD;
               nxt_cnt   = '0;
               nxt_wr    = dec_wr;
               nxt_rd    = dec_rd;
               nxt_phase = dec_bad ? PH_DROP : ((dec_wr != '0) ? PH_WDATA : PH_CRC);
            end
            PH_WDATA: begin
               kind = K_WDATA;
               idx  = cnt;
               if (cnt == wr_tgt - 13'd1) begin
                  nxt_phase = PH_CRC;
                  nxt_cnt   = '0;
               end else begin
                  nxt_cnt = cnt + 13'd1;
               end
            end
            PH_CRC: begin
               kind      = K_CRC;
               nxt_cnt   = '0;
               nxt_phase = (rd_tgt != '0) ? PH_RSLOT : PH_DONE;
            end
            PH_RSLOT: begin
               kind = K_RSLOT;
               idx  = cnt;
               if (cnt == rd_tgt - 13'd1) begin
                  nxt_phase = PH_DONE;
                  nxt_cnt   = '0;
               end else begin
                  nxt_cnt = cnt + 13'd1;
               end
            end
            PH_DONE: kind = K_EXTRA;
            default: kind = K_DROP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_DROP;
         cnt    <= '0;
         wr_tgt <= '0;
         rd_tgt <= '0;
      end else begin
         phase  <= nxt_phase;
         cnt    <= nxt_cnt;
         wr_tgt <= nxt_wr;
         rd_tgt <= nxt_rd;
      end
   end

   // R3: the data counter never passes the decoded word count
   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WDATA) |-> (cnt < wr_tgt));
   // R5: the slot counter never passes the decoded slot count
   a_r5_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RSLOT) |-> (cnt < rd_tgt));
   // R11: a lone frame-start pulse returns to the command phase
   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !word_valid) |=> (phase == PH_CMD));
endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
   import spi_cmd_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter bit TAG_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    word_valid,
   input  logic [WORD_W-1:0]       word_data,
   output logic                    tag_valid,
   output logic [2:0]              tag_kind,
   output logic [CNT_W-1:0]        tag_idx,
   output logic [WORD_W-1:0]       tag_word,
   output logic [3:0]              cmd_code,
   output logic [3:0]              cmd_addr,
   output logic [CNT_W-1:0]        cmd_wr_words,
   output logic [CNT_W-1:0]        cmd_rd_words,
   output logic [6:0]              cmd_end_bytes,
   output logic                    cmd_bad
);
   if (WORD_W != 16) begin : g_bad_width
      $error("spi_cmd_parser: the command layout needs WORD_W of 16");
   end

   cmd_info_t        dec;
   word_kind_e       kind_c;
   logic [CNT_W-1:0] idx_c;
   cmd_info_t        held;

   spi_cmd_field_dec #(.WORD_W(WORD_W)) u_dec (
      .word (word_data),
      .info (dec)
   );

   spi_frame_tracker u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .word_valid  (word_valid),
      .dec_bad     (dec.bad),
      .dec_wr      (dec.wr_words),
      .dec_rd      (dec.rd_words),
      .kind        (kind_c),
      .idx         (idx_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              held <= '0;
      else if (word_valid && kind_c == K_CMD)  held <= dec;
   end

   assign cmd_code      = held.code;
   assign cmd_addr      = held.addr;
   assign cmd_wr_words  = held.wr_words;
   assign cmd_rd_words  = held.rd_words;
   assign cmd_end_bytes = held.end_bytes;
   assign cmd_bad       = held.bad;

   if (TAG_REG) begin : g_tag_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_valid <= 1'b0;
            tag_kind  <= K_NONE;
            tag_idx   <= '0;
            tag_word  <= '0;
         end else begin
            tag_valid <= word_valid;
            tag_kind  <= kind_c;
            tag_idx   <= idx_c;
            tag_word  <= word_data;
         end
      end

      // R1: no tag kind without a valid strobe
      a_r1_idle_kind: assert property (@(posedge clk) disable iff (!rst_n)
         !tag_valid |-> (tag_kind == K_NONE));
      // R2: a command tag carries the latched code
      a_r2_code_match: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_valid && tag_kind == K_CMD) |-> (tag_word[15:12] == cmd_code));
      // R3: write-data index below the decoded count
      a_r3_wdata_bound: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_valid && tag_kind == K_WDATA) |-> (tag_idx < cmd_wr_words));
      // R5: read-slot index below the decoded count
      a_r5_rslot_bound: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_valid && tag_kind == K_RSLOT) |-> (tag_idx < cmd_rd_words));
      // R9: an illegal command is followed only by dropped words or a new command
      a_r9_drop_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_valid && tag_kind == K_CMD && cmd_bad) |=>
            (!tag_valid || tag_kind == K_DROP || tag_kind == K_CMD));
   end else begin : g_tag_comb
      assign tag_valid = word_valid;
      assign tag_kind  = kind_c;
      assign tag_idx   = idx_c;
      assign tag_word  = word_data;
   end
endmodule

// File: tb/spi_cmd_parser_bench.sv
module spi_cmd_parser_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        word_valid = 1'b0;
   logic [15:0] word_data = '0;
   logic        tag_valid;
   logic [2:0]  tag_kind;
   logic [12:0] tag_idx;
   logic [15:0] tag_word;
   logic [3:0]  cmd_code, cmd_addr;
   logic [12:0] cmd_wr_words, cmd_rd_words;
   logic [6:0]  cmd_end_bytes;
   logic        cmd_bad;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // 50 MHz: 20-unit period
   always #10 clk = ~clk;

   spi_cmd_parser u_spi_cmd_parser (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .word_valid(word_valid), .word_data(word_data),
      .tag_valid(tag_valid), .tag_kind(tag_kind), .tag_idx(tag_idx),
      .tag_word(tag_word), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .cmd_wr_words(cmd_wr_words), .cmd_rd_words(cmd_rd_words),
      .cmd_end_bytes(cmd_end_bytes), .cmd_bad(cmd_bad)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one cycle at negedge, sample just after the next posedge
   task automatic step(input logic fs, input logic v, input logic [15:0] w);
      @(negedge clk);
      frame_start = fs;
      word_valid  = v;
      word_data   = w;
      @(posedge clk);
      #1;
      frame_start = 1'b0;
      word_valid  = 1'b0;
   endtask

   // row: {frame_start, valid, word, expected kind, expected index}
   localparam int NV = 35;
   localparam logic [33:0] VEC [NV] = '{
      {1'b1,1'b0,16'h0000,3'd0,13'd0},  // R11 pulse only
      {1'b0,1'b1,16'h2002,3'd1,13'd0},  // R2 code 0x2, N=2
      {1'b0,1'b1,16'hAAAA,3'd2,13'd0},  // R3
      {1'b0,1'b0,16'h0000,3'd0,13'd0},  // R13 gap
      {1'b0,1'b1,16'hBBBB,3'd2,13'd1},  // R13 position held
      {1'b0,1'b1,16'hCCCC,3'd2,13'd2},  // R3
      {1'b0,1'b1,16'h1234,3'd3,13'd0},  // R3 CRC
      {1'b0,1'b1,16'h5555,3'd5,13'd0},  // R10 surplus
      {1'b1,1'b0,16'h0000,3'd0,13'd0},
      {1'b0,1'b1,16'h4000,3'd1,13'd0},  // R4 optional zero
      {1'b0,1'b1,16'h9999,3'd3,13'd0},  // R4 CRC at once
      {1'b1,1'b0,16'h0000,3'd0,13'd0},
      {1'b0,1'b1,16'h8001,3'd1,13'd0},  // R5 two slots
      {1'b0,1'b1,16'h4321,3'd3,13'd0},  // R5 CRC first
      {1'b0,1'b1,16'h0000,3'd4,13'd0},  // R5
      {1'b0,1'b1,16'h0000,3'd4,13'd1},  // R5
      {1'b0,1'b1,16'h0000,3'd5,13'd0},  // R10
      {1'b1,1'b0,16'h0000,3'd0,13'd0},
      {1'b0,1'b1,16'hF123,3'd1,13'd0},  // R9 illegal code
      {1'b0,1'b1,16'h2000,3'd6,13'd0},  // R9 dropped
      {1'b0,1'b1,16'h3000,3'd6,13'd0},  // R9 dropped
      {1'b1,1'b0,16'h0000,3'd0,13'd0},
      {1'b0,1'b1,16'hE1E1,3'd1,13'd0},  // R8 legal reset
      {1'b0,1'b1,16'h7777,3'd3,13'd0},  // R8 CRC next
      {1'b0,1'b1,16'h0000,3'd5,13'd0},  // R10
      {1'b1,1'b0,16'h0000,3'd0,13'd0},
      {1'b0,1'b1,16'hB031,3'd1,13'd0},  // R6 write, two words
      {1'b0,1'b1,16'h0101,3'd2,13'd0},  // R3
      {1'b1,1'b1,16'hD020,3'd1,13'd0},  // R11 restart with word same cycle
      {1'b0,1'b1,16'h0BAD,3'd3,13'd0},  // R5
      {1'b0,1'b1,16'h0000,3'd4,13'd0},  // R5 one slot
      {1'b0,1'b1,16'h0000,3'd5,13'd0},  // R10
      {1'b1,1'b0,16'h0000,3'd0,13'd0},
      {1'b0,1'b1,16'h5082,3'd1,13'd0},  // R4 N=1
      {1'b0,1'b1,16'h0042,3'd2,13'd0}   // R4
   };

   task automatic cmd_frame(input logic [15:0] w);
      step(1'b1, 1'b0, 16'h0);
      step(1'b0, 1'b1, w);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 tag_valid", {31'd0, tag_valid}, 32'd0);
      check("R1 tag_kind", {29'd0, tag_kind}, 32'd0);
      check("R1 cmd_bad", {31'd0, cmd_bad}, 32'd0);
      check("R1 cmd_code", {28'd0, cmd_code}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      step(1'b0, 1'b1, 16'h2001);
      check("R12 pre-frame kind", {29'd0, tag_kind}, 32'd6);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][33], VEC[i][32], VEC[i][31:16]);
         check($sformatf("R2/R3/R4/R5 row %0d valid", i), {31'd0, tag_valid}, {31'd0, VEC[i][32]});
         check($sformatf("R2/R3/R4/R5 row %0d kind", i), {29'd0, tag_kind}, {29'd0, VEC[i][15:13]});
         check($sformatf("R2/R3/R4/R5 row %0d idx", i), {19'd0, tag_idx}, {19'd0, VEC[i][12:0]});
      end

      cmd_frame(16'h3FFF);
      check("R3 code3 words", {19'd0, cmd_wr_words}, 32'd4096);
      check("R2 code", {28'd0, cmd_code}, 32'h3);
      cmd_frame(16'h4A85);
      check("R4 opt words", {19'd0, cmd_wr_words}, 32'd21);
      check("R4 end bytes", {25'd0, cmd_end_bytes}, 32'd5);
      cmd_frame(16'h707F);
      check("R3 code7 words", {19'd0, cmd_wr_words}, 32'd1);
      check("R4 end max", {25'd0, cmd_end_bytes}, 32'd127);
      cmd_frame(16'h90FF);
      check("R5 rd words", {19'd0, cmd_rd_words}, 32'd256);
      check("R5 bad clear", {31'd0, cmd_bad}, 32'd0);
      cmd_frame(16'hA0F2);
      check("R6 addr", {28'd0, cmd_addr}, 32'hF);
      check("R6 wr words", {19'd0, cmd_wr_words}, 32'd3);
      cmd_frame(16'hC005);
      check("R6 addr zero", {28'd0, cmd_addr}, 32'h0);
      check("R5 reg rd words", {19'd0, cmd_rd_words}, 32'd6);
      cmd_frame(16'hA1F2);
      check("R6 reserved bad", {31'd0, cmd_bad}, 32'd1);
      cmd_frame(16'h2200);
      check("R7 code2 reserved", {31'd0, cmd_bad}, 32'd1);
      cmd_frame(16'h8100);
      check("R7 code8 reserved", {31'd0, cmd_bad}, 32'd1);
      cmd_frame(16'hE1E0);
      check("R8 wrong key", {31'd0, cmd_bad}, 32'd1);
      cmd_frame(16'hE1E1);
      check("R8 good key", {31'd0, cmd_bad}, 32'd0);
      check("R8 no data", {19'd0, cmd_wr_words}, 32'd0);
      cmd_frame(16'h1000);
      check("R9 code1 bad", {31'd0, cmd_bad}, 32'd1);
      cmd_frame(16'h0000);
      check("R9 code0 bad", {31'd0, cmd_bad}, 32'd1);
      step(1'b0, 1'b1, 16'hB000);
      check("R9 drop", {29'd0, tag_kind}, 32'd6);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule